// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

A host processor cannot address PCI-style configuration space directly. It reaches it through two words in the bridge's small register space: an address word and a data window. The host writes the address word, which packs an enable flag, a bus number, a device number, a function number and a dword register number. It then reads or writes the data window. A data-window access becomes one request on a simple configuration-target interface. The request carries the decoded fields, a 4-bit byte-lane enable and lane-aligned write data. The request stays up until the target acknowledges it. If the target never answers, a timeout ends the request and the access returns all ones.

Byte and halfword accesses go to the data window at offsets 0x2C to 0x2F. The two low address bits select the starting byte lane. Sub-word read data is shifted down from the addressed dword. Accesses aimed at bus 0, device 0 never leave the bridge. They are served by a local dword register file. The register space also holds four plain storage words for bridge setup: I/O window size, protection, control and soft-reset.

The host interface is a request/acknowledge handshake. The host holds `req_i` and its qualifiers until `ack_o` pulses, then drops the request.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset, `ack_o` and `cfg_req_o` are low, and the address word and all four storage words read as zero.
- R2: The address word at offset 0x28 reads back as written. Its fields decode as follows: bit 31 is enable, bits 23..16 are bus, bits 15..11 are device, bits 10..8 are function, and bits 7..2 are the register number. Bits 1..0 do not affect the register number.
- R3: A data-window access with enable set and a target other than bus 0 / device 0 raises `cfg_req_o` one cycle after acceptance. The request carries the decoded fields and holds them steady until `cfg_ack_i` is sampled high. On that edge `cfg_req_o` drops, and `ack_o` pulses with the response data one cycle after `cfg_ack_i` was driven.
- R4: The data-window offset 0x2C+n selects lane n. With `size_i` 0 (byte) the byte enable is lane n only. With 1 (halfword) it is lanes n and n+1, and a halfword at lane 3 enables lane 3 only. With 2 or 3 (word) all four lanes are enabled with no shift. Write data is shifted up by 8*n for sub-word sizes.
- R5: Read data is the addressed dword shifted right by 8*n and masked to 8 bits for a byte or 16 bits for a halfword. A word read returns the whole dword.
- R6: With the enable bit clear, a data-window read returns the all-ones dword reduced as in R5. A write is discarded. No target request is raised, and `ack_o` pulses one cycle after acceptance.
- R7: Bus 0 / device 0, with any function, selects a local file of LOCAL_WORDS dwords indexed by register number. Writes follow the byte enables of R4, and `ack_o` comes one cycle after acceptance with no target request. A register number at or above LOCAL_WORDS reads zero and drops writes. A non-zero bus or device goes to the target.
- R8: If `cfg_ack_i` is not sampled high within TIMEOUT cycles of request, the request drops and the access completes. The read data is the all-ones dword reduced as in R5. A `cfg_ack_i` in the last cycle of the window still delivers target data.
- R9: Offsets 0x00, 0x04, 0x08 and 0x10 are full-word storage: any size writes the whole word. Other offsets outside the address word and the data window read zero and ignore writes. Both complete one cycle after acceptance.
- R10: `ack_o` is a one-cycle pulse, and no access is accepted in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until ack_o |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | ADDR_W | Host byte address in bridge register space |
| size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| wdata_i | input | 32 | Host write data, right-aligned |
| ack_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Read data, valid with ack_o |
| cfg_req_o | output | 1 | Configuration target request |
| cfg_we_o | output | 1 | Target write strobe qualifier |
| cfg_bus_o | output | 8 | Decoded bus number |
| cfg_dev_o | output | 5 | Decoded device number |
| cfg_fn_o | output | 3 | Decoded function number |
| cfg_reg_o | output | 6 | Decoded dword register number |
| cfg_be_o | output | 4 | Byte-lane enables |
| cfg_wdata_o | output | 32 | Lane-aligned write data |
| cfg_ack_i | input | 1 | Target acknowledge |
| cfg_rdata_i | input | 32 | Target read dword |

## Verification
The data window is driven with bytes at every lane, halfwords that do and do not cross the top lane, and word accesses at unaligned offsets. This separates lane selection, byte-enable truncation and read shifting. The same sizes are run against the local file, against a responding target with several acknowledge delays, and against a silent target. This shows routing, the request hold and the timeout boundary, where an acknowledge in the last cycle must still win. Enable-clear writes are followed by enabled reads of the same dword, which shows they were discarded. Bus-only and device-only non-zero targets show that only the exact bus 0 / device 0 pair stays local.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  localparam int CMD_WORD  = 10;  // byte offset 0x28
  localparam int DATA_WORD = 11;  // byte offset 0x2C
  localparam int NMISC     = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_DONE} st_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] regn;
  } cfg_addr_t;

  // word index of storage register i: 0x00, 0x04, 0x08, 0x10
  function automatic int misc_word(int i);
    return (i == 3) ? 4 : i;
  endfunction

  function automatic logic [3:0] lane_be(logic [1:0] sz, logic [1:0] ln);
    case (sz)
      2'd0:    return 4'b0001 << ln;
      2'd1:    return 4'b0011 << ln;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] lane_place(logic [31:0] v, logic [1:0] sz, logic [1:0] ln);
    return sz[1] ? v : (v << {ln, 3'b000});
  endfunction

  function automatic logic [31:0] lane_extract(logic [31:0] dw, logic [1:0] sz, logic [1:0] ln);
    logic [31:0] sh;
    sh = dw >> {ln, 3'b000};
    case (sz)
      2'd0:    return {24'h0, sh[7:0]};
      2'd1:    return {16'h0, sh[15:0]};
      default: return dw;
    endcase
  endfunction

endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
  import cfg_window_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] word_o,
  output cfg_addr_t   dec_o
);
  logic [31:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (we_i) word_q <= wdata_i;
  end

  assign word_o     = word_q;
  assign dec_o.en   = word_q[31];
  assign dec_o.bus  = word_q[23:16];
  assign dec_o.dev  = word_q[15:11];
  assign dec_o.fn   = word_q[10:8];
  assign dec_o.regn = word_q[7:2];
endmodule

// File: rtl/cfg_local_file.sv
module cfg_local_file #(
  parameter int LOCAL_WORDS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [5:0]  regn_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int IDX_W = (LOCAL_WORDS > 1) ? $clog2(LOCAL_WORDS) : 1;

  logic [31:0]      mem_q [LOCAL_WORDS];
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = int'(regn_i) < LOCAL_WORDS;
  assign idx = IDX_W'(regn_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LOCAL_WORDS; i++) mem_q[i] <= '0;
    end else if (we_i && hit) begin
      for (int b = 0; b < 4; b++)
        if (be_i[b]) mem_q[idx][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rdata_o = hit ? mem_q[idx] : '0;
endmodule

// File: rtl/cfg_misc_regs.sv
module cfg_misc_regs
  import cfg_window_pkg::*;
#(
  parameter int WIDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic [31:0] regs_q [NMISC];

  for (genvar g = 0; g < NMISC; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && widx_i == WIDX_W'(misc_word(g))) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NMISC; i++)
      if (widx_i == WIDX_W'(misc_word(i))) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/cfg_timeout.sv
module cfg_timeout #(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CNT_W'(TIMEOUT - 1));
endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfg_window_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int LOCAL_WORDS = 16,
  parameter int TIMEOUT     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              ack_o,
  output logic [31:0]       rdata_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [7:0]        cfg_bus_o,
  output logic [4:0]        cfg_dev_o,
  output logic [2:0]        cfg_fn_o,
  output logic [5:0]        cfg_reg_o,
  output logic [3:0]        cfg_be_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic [31:0]       cfg_rdata_i
);
  localparam int WIDX_W = ADDR_W - 2;

  st_e               st_q;
  cfg_addr_t         cmd;
  logic [31:0]       cmd_word, loc_rd, misc_rd, imm_rd, wplace;
  logic [WIDX_W-1:0] widx;
  logic [1:0]        lane, size_q, lane_q;
  logic [3:0]        be_w;
  logic              accept, hit_data, hit_cmd, is_local, go_ext;
  logic              loc_we, cmd_we, misc_we, expired;

  assign accept   = req_i && (st_q == ST_IDLE);
  assign widx     = addr_i[ADDR_W-1:2];
  assign lane     = addr_i[1:0];
  assign hit_data = (widx == WIDX_W'(DATA_WORD));
  assign hit_cmd  = (widx == WIDX_W'(CMD_WORD));
  assign is_local = (cmd.bus == '0) && (cmd.dev == '0);
  assign be_w     = lane_be(size_i, lane);
  assign wplace   = lane_place(wdata_i, size_i, lane);
  assign go_ext   = accept && hit_data && cmd.en && !is_local;
  assign loc_we   = accept && hit_data && cmd.en && is_local && we_i;
  assign cmd_we   = accept && hit_cmd && we_i;
  assign misc_we  = accept && we_i && !hit_data && !hit_cmd;

  cfg_cmd_reg u_cmd (
    .clk_i, .rst_ni, .we_i(cmd_we), .wdata_i, .word_o(cmd_word), .dec_o(cmd)
  );

  cfg_local_file #(.LOCAL_WORDS(LOCAL_WORDS)) u_local (
    .clk_i, .rst_ni, .we_i(loc_we), .regn_i(cmd.regn), .be_i(be_w),
    .wdata_i(wplace), .rdata_o(loc_rd)
  );

  cfg_misc_regs #(.WIDX_W(WIDX_W)) u_misc (
    .clk_i, .rst_ni, .we_i(misc_we), .widx_i(widx), .wdata_i, .rdata_o(misc_rd)
  );

  cfg_timeout #(.TIMEOUT(TIMEOUT)) u_to (
    .clk_i, .rst_ni, .run_i(st_q == ST_EXT), .expired_o(expired)
  );

  // response for accesses completed without the target
  always_comb begin
    if (hit_data)     imm_rd = lane_extract(cmd.en ? loc_rd : '1, size_i, lane);
    else if (hit_cmd) imm_rd = cmd_word;
    else              imm_rd = misc_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ack_o       <= 1'b0;
      rdata_o     <= '0;
      cfg_req_o   <= 1'b0;
      cfg_we_o    <= 1'b0;
      cfg_bus_o   <= '0;
      cfg_dev_o   <= '0;
      cfg_fn_o    <= '0;
      cfg_reg_o   <= '0;
      cfg_be_o    <= '0;
      cfg_wdata_o <= '0;
      size_q      <= '0;
      lane_q      <= '0;
    end else begin
      ack_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (go_ext) begin
            st_q        <= ST_EXT;
            cfg_req_o   <= 1'b1;
            cfg_we_o    <= we_i;
            cfg_bus_o   <= cmd.bus;
            cfg_dev_o   <= cmd.dev;
            cfg_fn_o    <= cmd.fn;
            cfg_reg_o   <= cmd.regn;
            cfg_be_o    <= be_w;
            cfg_wdata_o <= wplace;
            size_q      <= size_i;
            lane_q      <= lane;
          end else begin
            st_q    <= ST_DONE;
            ack_o   <= 1'b1;
            rdata_o <= imm_rd;
          end
        end
        ST_EXT: if (cfg_ack_i || expired) begin
          st_q      <= ST_DONE;
          cfg_req_o <= 1'b0;
          ack_o     <= 1'b1;
          rdata_o   <= lane_extract(cfg_ack_i ? cfg_rdata_i : '1, size_q, lane_q);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int TIMEOUT = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ack_o,
  input logic        cfg_req_o,
  input logic        cfg_ack_i,
  input logic        cfg_we_o,
  input logic [7:0]  cfg_bus_o,
  input logic [4:0]  cfg_dev_o,
  input logic [2:0]  cfg_fn_o,
  input logic [5:0]  cfg_reg_o,
  input logic [3:0]  cfg_be_o,
  input logic [31:0] cfg_wdata_o
);
  localparam int RW = $clog2(TIMEOUT + 1) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (!cfg_req_o) run_q <= '0;
    else if (int'(run_q) <= TIMEOUT) run_q <= run_q + 1'b1;
  end

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R10
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o || ack_o); // R3
  AST_REQ_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i |=> !cfg_req_o && ack_o); // R3
  AST_FIELDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && $past(cfg_req_o) |-> $stable({cfg_we_o, cfg_bus_o, cfg_dev_o,
      cfg_fn_o, cfg_reg_o, cfg_be_o, cfg_wdata_o})); // R3
  AST_BE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> cfg_be_o != 4'b0000 && cfg_be_o != 4'b0101 && cfg_be_o != 4'b1010); // R4
  AST_NO_LOCAL_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_bus_o != 8'h0) || (cfg_dev_o != 5'h0)); // R7
  AST_TIMEOUT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> int'(run_q) < TIMEOUT); // R8
endmodule

bind cfg_window_bridge cfg_window_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .cfg_req_o(cfg_req_o),
  .cfg_ack_i(cfg_ack_i), .cfg_we_o(cfg_we_o), .cfg_bus_o(cfg_bus_o),
  .cfg_dev_o(cfg_dev_o), .cfg_fn_o(cfg_fn_o), .cfg_reg_o(cfg_reg_o),
  .cfg_be_o(cfg_be_o), .cfg_wdata_o(cfg_wdata_o)
);

// File: tb/cfg_window_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_window_bridge_tb_top;
  localparam int TO = 8;
  localparam int LW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ack, cfg_req, cfg_we, cfg_ack = 1'b0;
  logic [5:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0, rdata, cfg_wdata, cfg_rdata = '0;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;

  always #2.5 clk = ~clk;

  cfg_window_bridge #(.ADDR_W(6), .LOCAL_WORDS(LW), .TIMEOUT(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_bus_o(cfg_bus),
    .cfg_dev_o(cfg_dev), .cfg_fn_o(cfg_fn), .cfg_reg_o(cfg_reg),
    .cfg_be_o(cfg_be), .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack),
    .cfg_rdata_i(cfg_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] cmd_m = '0;
  logic [31:0] misc_m [int];
  logic [31:0] loc_m [LW];
  logic [31:0] ext_m [int];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pick(logic [31:0] dw, int sz, int ln);
    logic [31:0] v;
    if (sz >= 2) return dw;
    v = dw >> (8 * ln);
    return (sz == 0) ? (v & 32'hFF) : (v & 32'hFFFF);
  endfunction

  function automatic logic [3:0] be_of(int sz, int ln);
    if (sz >= 2) return 4'hF;
    if (sz == 0) return 4'(1 << ln);
    return 4'((3 << ln) & 15);
  endfunction

  function automatic logic [31:0] place(logic [31:0] v, int sz, int ln);
    return (sz >= 2) ? v : (v << (8 * ln));
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] ext_get(int key);
    if (ext_m.exists(key)) return ext_m[key];
    return {10'h2A5, 22'(key)};
  endfunction

  // delay: cycles until the bench target acknowledges; 0 = silent target
  task automatic access(input bit w, input int a, input int sz, input logic [31:0] wd,
                        input int delay, input string tag, output logic [31:0] got);
    int widx = a >> 2, ln = a & 3, lat = 1, key;
    bit ext = 0;
    logic [31:0] exp_rd = '0, dw;
    logic [3:0] be = be_of(sz, ln);
    key = {cmd_m[23:8], cmd_m[7:2]};
    if (widx == 11) begin
      if (!cmd_m[31]) exp_rd = pick('1, sz, ln);
      else if (cmd_m[23:11] == 0) begin
        if (cmd_m[7:2] < LW) begin
          if (w) loc_m[cmd_m[7:2]] = merge(loc_m[cmd_m[7:2]], place(wd, sz, ln), be);
          exp_rd = pick(loc_m[cmd_m[7:2]], sz, ln);
        end
      end else begin
        ext = 1;
        lat = (delay == 0) ? TO + 1 : delay + 1;
        dw = (delay == 0) ? '1 : ext_get(key);
        exp_rd = pick(dw, sz, ln);
        if (w && delay != 0) ext_m[key] = merge(ext_get(key), place(wd, sz, ln), be);
      end
    end else if (widx == 10) begin
      if (w) cmd_m = wd;
      exp_rd = cmd_m;
    end else if (widx == 0 || widx == 1 || widx == 2 || widx == 4) begin
      if (w) misc_m[widx] = wd;
      exp_rd = misc_m.exists(widx) ? misc_m[widx] : '0;
    end
    req = 1'b1; we = w; addr = 6'(a); size = 2'(sz); wdata = wd;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      cfg_ack = 1'b0;
      if (ext) begin
        chk({tag, " cfg_req"}, {31'h0, cfg_req}, {31'h0, c < lat});
        if (c == 1) begin
          chk({tag, " bus"}, {24'h0, cfg_bus}, {24'h0, cmd_m[23:16]});
          chk({tag, " dev"}, {27'h0, cfg_dev}, {27'h0, cmd_m[15:11]});
          chk({tag, " fn"},  {29'h0, cfg_fn},  {29'h0, cmd_m[10:8]});
          chk({tag, " reg"}, {26'h0, cfg_reg}, {26'h0, cmd_m[7:2]});
          chk({tag, " be"},  {28'h0, cfg_be},  {28'h0, be});
          chk({tag, " we"},  {31'h0, cfg_we},  {31'h0, w});
          if (w) chk({tag, " wdata"}, cfg_wdata, place(wd, sz, ln));
        end
        if (delay != 0 && c == delay) begin
          cfg_ack = 1'b1;
          cfg_rdata = dw;
        end
      end else begin
        chk({tag, " no cfg_req"}, {31'h0, cfg_req}, 32'h0);
      end
      chk({tag, " ack timing"}, {31'h0, ack}, {31'h0, c == lat});
    end
    if (!w) chk({tag, " rdata"}, rdata, exp_rd);
    got = rdata;
    req = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R10 ack single pulse", {31'h0, ack}, 32'h0);
  endtask

  function automatic logic [31:0] cmd_word(bit en, int bus, int dev, int fn, int rn, int lo);
    return {en, 7'h0, 8'(bus), 5'(dev), 3'(fn), 6'(rn), 2'(lo)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    for (int i = 0; i < LW; i++) loc_m[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack reset", {31'h0, ack}, 32'h0);
    chk("R1 cfg_req reset", {31'h0, cfg_req}, 32'h0);
    access(0, 'h28, 2, 0, 0, "R1 cmd reset", g);
    access(0, 'h08, 2, 0, 0, "R1 ctrl reset", g);
    access(0, 'h10, 2, 0, 0, "R1 softrst reset", g);

    // storage words
    access(1, 'h00, 2, 32'hA1B2C3D4, 0, "R9 wr 00", g);
    access(1, 'h04, 0, 32'h11223344, 0, "R9 wr 04 byte size", g);
    access(1, 'h08, 2, 32'h0BADF00D, 0, "R9 wr 08", g);
    access(1, 'h10, 1, 32'h55AA33CC, 0, "R9 wr 10", g);
    access(0, 'h00, 2, 0, 0, "R9 rd 00", g);
    access(0, 'h04, 2, 0, 0, "R9 rd 04", g);
    chk("R9 full word stored", g, 32'h11223344);
    access(0, 'h08, 2, 0, 0, "R9 rd 08", g);
    access(0, 'h10, 2, 0, 0, "R9 rd 10", g);
    access(1, 'h0C, 2, 32'hDEADBEEF, 0, "R9 wr 0C", g);
    access(0, 'h0C, 2, 0, 0, "R9 rd 0C", g);
    chk("R9 hole reads zero", g, 32'h0);
    access(0, 'h30, 2, 0, 0, "R9 rd 30", g);

    // enable clear
    access(1, 'h28, 2, cmd_word(0, 0, 0, 0, 1, 0), 0, "R2 cmd", g);
    access(1, 'h2C, 2, 32'h12345678, 0, "R6 wr disabled", g);
    access(0, 'h2C, 2, 0, 0, "R6 rd disabled", g);
    chk("R6 all ones", g, 32'hFFFFFFFF);
    access(0, 'h2E, 0, 0, 0, "R6 byte rd disabled", g);
    access(1, 'h28, 2, cmd_word(1, 0, 0, 0, 1, 0), 0, "R2 cmd", g);
    access(0, 'h2C, 2, 0, 0, "R6 write discarded", g);
    chk("R6 discarded write", g, 32'h0);

    // local file lanes
    access(1, 'h28, 2, cmd_word(1, 0, 0, 3, 2, 0), 0, "R2 cmd", g);
    access(1, 'h2C, 2, 32'h11223344, 0, "R7 wr word", g);
    access(1, 'h2D, 0, 32'h000000AA, 0, "R4 byte lane1", g);
    access(1, 'h2E, 1, 32'h0000BEEF, 0, "R4 half lane2", g);
    access(1, 'h2F, 1, 32'h00005566, 0, "R4 half lane3 truncated", g);
    access(0, 'h2C, 2, 0, 0, "R4 local word", g);
    chk("R4 lane merge", g, 32'h66EFAA44);
    access(0, 'h2D, 0, 0, 0, "R5 byte lane1", g);
    chk("R5 byte extract", g, 32'h000000AA);
    access(0, 'h2E, 1, 0, 0, "R5 half lane2", g);
    chk("R5 half extract", g, 32'h000066EF);
    access(0, 'h2F, 1, 0, 0, "R5 half lane3", g);
    access(0, 'h2C, 0, 0, 0, "R5 byte lane0", g);
    access(0, 'h2D, 2, 0, 0, "R4 word unaligned", g);
    access(1, 'h28, 2, cmd_word(1, 0, 0, 6, 2, 3), 0, "R2 cmd", g);
    access(0, 'h2C, 2, 0, 0, "R7 other function local", g);
    access(1, 'h28, 2, cmd_word(1, 0, 0, 0, LW + 4, 0), 0, "R2 cmd", g);
    access(1, 'h2C, 2, 32'hFACEFACE, 0, "R7 wr out of range", g);
    access(0, 'h2C, 2, 0, 0, "R7 rd out of range", g);
    chk("R7 beyond file", g, 32'h0);

    // external target
    access(1, 'h28, 2, cmd_word(1, 8'h5A, 5'h13, 5, 6'h2D, 3), 0, "R2 cmd", g);
    access(0, 'h28, 2, 0, 0, "R2 readback", g);
    chk("R2 cmd readback", g, 32'h805A9DB7);
    access(1, 'h2C, 2, 32'hCAFEF00D, 2, "R3 wr word d2", g);
    access(0, 'h2C, 2, 0, 1, "R3 rd word d1", g);
    chk("R3 target data", g, 32'hCAFEF00D);
    access(1, 'h2D, 0, 32'h00000077, 3, "R4 ext byte lane1", g);
    access(0, 'h2E, 1, 0, 4, "R5 ext half lane2", g);
    chk("R5 ext half", g, 32'h0000CAFE);
    access(0, 'h2D, 0, 0, 2, "R5 ext byte lane1", g);
    chk("R5 ext byte", g, 32'h00000077);
    access(1, 'h2F, 1, 32'h0000ABCD, 1, "R4 ext half lane3", g);
    access(0, 'h2C, 2, 0, 1, "R4 ext after lane3", g);
    access(1, 'h28, 2, cmd_word(1, 0, 1, 0, 4, 0), 0, "R2 cmd", g);
    access(0, 'h2C, 2, 0, 2, "R7 dev1 goes out", g);
    access(1, 'h28, 2, cmd_word(1, 1, 0, 0, 4, 0), 0, "R2 cmd", g);
    access(0, 'h2C, 2, 0, 1, "R7 bus1 goes out", g);

    // timeout
    access(1, 'h28, 2, cmd_word(1, 7, 2, 1, 3, 0), 0, "R2 cmd", g);
    access(0, 'h2C, 2, 0, 0, "R8 silent word", g);
    chk("R8 timeout ones", g, 32'hFFFFFFFF);
    access(0, 'h2E, 0, 0, 0, "R8 silent byte", g);
    chk("R8 timeout byte", g, 32'h000000FF);
    access(1, 'h2C, 2, 32'h01020304, 0, "R8 silent write", g);
    access(0, 'h2C, 2, 0, TO, "R8 ack on last cycle", g);
    access(0, 'h2C, 2, 0, TO - 1, "R8 ack before last", g);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule